// File: doc/BRIEF.md
# Page Table Address Translator

This block turns a virtual address into a physical address by fetching one entry from a page table held in memory. The requester presents a virtual address together with an access kind (read or write) and a flag saying whether it runs in supervisor mode. The block works out where the entry lives from a programmable table base and the virtual page number, and reads it through a memory port whose response time may vary.

When the entry arrives, the block decodes its presence and permission bits. It then answers with either a physical address or a two-bit fault code. The page offset passes through unchanged. The physical page number comes from the entry.

The block handles one lookup at a time. It keeps its response on the outputs until the requester takes it.

Top module: `pt_translator`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `mem_req` is 0, and the table base equals the `BASE_RESET` parameter.
- R2: For an accepted request, `mem_addr` equals the table base plus four times the virtual page number. The virtual page number is `req_vaddr` with its low `PAGE_BITS` bits removed. `mem_req` stays high with `mem_addr` stable until a cycle with `mem_ack` high.
- R3: An entry whose bit 0 (present) is 0 gives fault code 01 and a `rsp_paddr` of zero. This check has the highest priority.
- R4: A present entry whose bit 3 (supervisor-only) is 1 gives fault code 10 and a `rsp_paddr` of zero when `req_super` is 0.
- R5: A present entry that passes the supervisor check gives fault code 11 and a `rsp_paddr` of zero in two cases: a write (`req_write`=1) when bit 2 (write allowed) is 0, or a read when bit 1 (read allowed) is 0.
- R6: An entry that passes every check gives fault code 00. `rsp_paddr` is then the entry bits starting at bit 4 (physical page number, `PA_W-PAGE_BITS` bits wide) placed above the unchanged low `PAGE_BITS` bits of the virtual address.
- R7: `req_ready` is high only while no lookup is in progress. Once `rsp_valid` rises, `rsp_valid`, `rsp_paddr` and `rsp_fault` hold their values until a cycle with `rsp_ready` high.
- R8: A write to the table base (`base_we`) takes effect only while `req_ready` is high. A write made while a lookup is in progress is ignored. A write in the same cycle a request is accepted applies from the next request onward.
- R9: The result depends only on the entry contents. The number of wait cycles before `mem_ack` does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Table base write strobe |
| base_wdata | input | MADDR_W | New table base byte address |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_vaddr | input | VA_W | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_super | input | 1 | Requester is in supervisor mode |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | PA_W | Physical address (zero on fault) |
| rsp_fault | output | 2 | 00 ok, 01 not present, 10 supervisor, 11 read/write |
| mem_req | output | 1 | Entry read request |
| mem_addr | output | MADDR_W | Entry byte address |
| mem_ack | input | 1 | Entry data valid this cycle |
| mem_rdata | input | 32 | Entry contents |

## Verification
The bench builds the block with 16-bit virtual, physical and memory addresses and 256-byte pages, so it can sweep all 256 virtual pages. Each page is tried with reads and writes in both user and supervisor mode. The bench's memory model makes the low four bits of each entry equal the low four bits of its word index. Because of that, the sweep covers every combination of present, read, write and supervisor bits, and so every branch of the fault priority. The acknowledge delay is pseudo-random, and two directed runs with fixed delays show that latency does not change the result. Directed sequences also cover base writes while idle, while busy, and in the same cycle as an accepted request, and responses held back by `rsp_ready`.

// File: rtl/pt_pkg.sv
package pt_pkg;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_ABSENT = 2'b01,
    FLT_SUPER = 2'b10,
    FLT_RW    = 2'b11
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RESP  = 2'd2
  } walk_state_e;

  localparam int ENT_PRESENT = 0;
  localparam int ENT_RD      = 1;
  localparam int ENT_WR      = 2;
  localparam int ENT_SUPER   = 3;
  localparam int ENT_PPN_LSB = 4;
  localparam int ENT_BYTES_LOG2 = 2;

endpackage

// File: rtl/pt_base_reg.sv
module pt_base_reg #(
  parameter int MADDR_W = 32,
  parameter logic [MADDR_W-1:0] BASE_RESET = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [MADDR_W-1:0] wdata,
  input  logic               idle,
  output logic [MADDR_W-1:0] base
);

  always_ff @(posedge clk) begin
    if (rst) begin
      base <= BASE_RESET;
    end else if (we && idle) begin
      base <= wdata;
    end
  end

endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check
  import pt_pkg::*;
#(
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic [31:0]          entry,
  input  logic [PAGE_BITS-1:0] offset,
  input  logic                 is_write,
  input  logic                 is_super,
  output fault_e               fault,
  output logic [PA_W-1:0]      paddr
);

  localparam int PPN_W = PA_W - PAGE_BITS;

  logic [PPN_W-1:0] ppn;
  logic present, may_rd, may_wr, sup_only;

  assign ppn      = entry[ENT_PPN_LSB +: PPN_W];
  assign present  = entry[ENT_PRESENT];
  assign may_rd   = entry[ENT_RD];
  assign may_wr   = entry[ENT_WR];
  assign sup_only = entry[ENT_SUPER];

  always_comb begin
    if (!present) begin
      fault = FLT_ABSENT;
    end else if (sup_only && !is_super) begin
      fault = FLT_SUPER;
    end else if (is_write ? !may_wr : !may_rd) begin
      fault = FLT_RW;
    end else begin
      fault = FLT_NONE;
    end
  end

  always_comb begin
    if (fault == FLT_NONE) begin
      paddr = {ppn, offset};
    end else begin
      paddr = '0;
    end
  end

endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int MADDR_W   = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [VA_W-1:0]      req_vaddr,
  input  logic                 req_write,
  input  logic                 req_super,
  input  logic [MADDR_W-1:0]   base,
  output logic [PAGE_BITS-1:0] cap_offset,
  output logic                 cap_write,
  output logic                 cap_super,
  output logic                 mem_req,
  output logic [MADDR_W-1:0]   mem_addr,
  input  logic                 mem_ack,
  input  fault_e               chk_fault,
  input  logic [PA_W-1:0]      chk_paddr,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [PA_W-1:0]      rsp_paddr,
  output logic [1:0]           rsp_fault
);

  localparam int VPN_W = VA_W - PAGE_BITS;

  walk_state_e state;
  logic [VPN_W-1:0] vpn;

  assign vpn       = req_vaddr[VA_W-1:PAGE_BITS];
  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      cap_offset <= '0;
      cap_write  <= 1'b0;
      cap_super  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_paddr  <= '0;
      rsp_fault  <= 2'b00;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cap_offset <= req_vaddr[PAGE_BITS-1:0];
            cap_write  <= req_write;
            cap_super  <= req_super;
            mem_addr   <= base + (MADDR_W'(vpn) << ENT_BYTES_LOG2);
            mem_req    <= 1'b1;
            state      <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_paddr <= chk_paddr;
            rsp_fault <= chk_fault;
            state     <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pt_translator.sv
module pt_translator
  import pt_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int MADDR_W   = 32,
  parameter logic [MADDR_W-1:0] BASE_RESET = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               base_we,
  input  logic [MADDR_W-1:0] base_wdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_write,
  input  logic               req_super,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic [1:0]         rsp_fault,
  output logic               mem_req,
  output logic [MADDR_W-1:0] mem_addr,
  input  logic               mem_ack,
  input  logic [31:0]        mem_rdata
);

  logic [MADDR_W-1:0]   base_q;
  logic [PAGE_BITS-1:0] cap_offset;
  logic                 cap_write;
  logic                 cap_super;
  fault_e               chk_fault;
  logic [PA_W-1:0]      chk_paddr;

  pt_base_reg #(
    .MADDR_W   (MADDR_W),
    .BASE_RESET(BASE_RESET)
  ) u_base (
    .clk  (clk),
    .rst  (rst),
    .we   (base_we),
    .wdata(base_wdata),
    .idle (req_ready),
    .base (base_q)
  );

  pt_perm_check #(
    .PA_W     (PA_W),
    .PAGE_BITS(PAGE_BITS)
  ) u_check (
    .entry   (mem_rdata),
    .offset  (cap_offset),
    .is_write(cap_write),
    .is_super(cap_super),
    .fault   (chk_fault),
    .paddr   (chk_paddr)
  );

  pt_walk_ctrl #(
    .VA_W     (VA_W),
    .PA_W     (PA_W),
    .PAGE_BITS(PAGE_BITS),
    .MADDR_W  (MADDR_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_vaddr (req_vaddr),
    .req_write (req_write),
    .req_super (req_super),
    .base      (base_q),
    .cap_offset(cap_offset),
    .cap_write (cap_write),
    .cap_super (cap_super),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .chk_fault (chk_fault),
    .chk_paddr (chk_paddr),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault)
  );

endmodule

// File: rtl/pt_translator_chk.sv
module pt_translator_chk #(
  parameter int PA_W    = 32,
  parameter int MADDR_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [PA_W-1:0]    rsp_paddr,
  input logic [1:0]         rsp_fault,
  input logic               mem_req,
  input logic [MADDR_W-1:0] mem_addr,
  input logic               mem_ack,
  input logic [MADDR_W-1:0] base
);

  assert_mem_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_fault_zero_addr_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 2'b00) |-> (rsp_paddr == '0));

  assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  assert_ready_idle_R7: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!rsp_valid && !mem_req));

  assert_base_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> $stable(base));

  assert_rsp_after_ack_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> $past(mem_ack));

endmodule

bind pt_translator pt_translator_chk #(
  .PA_W   (PA_W),
  .MADDR_W(MADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault),
  .mem_req  (mem_req),
  .mem_addr (mem_addr),
  .mem_ack  (mem_ack),
  .base     (base_q)
);

// File: tb/test_pt_translator.sv
module test_pt_translator;

  localparam int VA_W = 16;
  localparam int PA_W = 16;
  localparam int PAGE_BITS = 8;
  localparam int MADDR_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic base_we = 1'b0;
  logic [MADDR_W-1:0] base_wdata = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [VA_W-1:0] req_vaddr = '0;
  logic req_write = 1'b0;
  logic req_super = 1'b0;
  logic rsp_valid;
  logic rsp_ready = 1'b0;
  logic [PA_W-1:0] rsp_paddr;
  logic [1:0] rsp_fault;
  logic mem_req;
  logic [MADDR_W-1:0] mem_addr;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  int fixed_wait = -1;
  int wait_left = 0;
  logic [7:0] lfsr = 8'hA5;
  logic [MADDR_W-1:0] seen_addr;
  logic [PA_W-1:0] got_pa;
  logic [1:0] got_flt;

  always #4 clk = ~clk;

  pt_translator #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .MADDR_W(MADDR_W),
    .BASE_RESET(16'h0000)
  ) i_pt_translator (
    .clk(clk), .rst(rst), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_super(req_super), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] entry_of(input logic [MADDR_W-1:0] addr);
    logic [13:0] w;
    logic [7:0] ppn;
    w = addr[15:2];
    ppn = 8'(w * 37 + 5);
    return {20'hFACE5, ppn, w[3:0]};
  endfunction

  // memory model, driven away from the active edge
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (wait_left > 0) begin
        wait_left <= wait_left - 1;
      end else begin
        mem_ack   <= 1'b1;
        mem_rdata <= entry_of(mem_addr);
        lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        wait_left <= (fixed_wait >= 0) ? fixed_wait : int'(lfsr[1:0]);
      end
    end
  end

  task automatic check(input string req, input logic ok, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one full lookup; hold = cycles rsp_ready is held low after rsp_valid
  task automatic lookup(input logic [VA_W-1:0] va, input logic wr, input logic sup,
                        input int hold);
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_super = sup; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) begin
      if (mem_req) seen_addr = mem_addr;
      @(negedge clk);
    end
    got_pa = rsp_paddr; got_flt = rsp_fault;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check("R7 hold", rsp_valid && rsp_paddr == got_pa && rsp_fault == got_flt,
            {rsp_valid, rsp_fault, rsp_paddr}, {1'b1, got_flt, got_pa});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic expect_result(input logic [MADDR_W-1:0] base, input logic [VA_W-1:0] va,
                               input logic wr, input logic sup);
    logic [MADDR_W-1:0] ea;
    logic [31:0] e;
    logic [1:0] ef;
    logic [PA_W-1:0] ep;
    ea = base + {va[15:8], 2'b00};
    e = entry_of(ea);
    if (!e[0]) ef = 2'b01;
    else if (e[3] && !sup) ef = 2'b10;
    else if (wr ? !e[2] : !e[1]) ef = 2'b11;
    else ef = 2'b00;
    ep = (ef == 2'b00) ? {e[11:4], va[7:0]} : '0;
    check("R2 entry address", seen_addr == ea, 32'(seen_addr), 32'(ea));
    case (ef)
      2'b01: check("R3 not present", got_flt == ef && got_pa == ep, {got_flt, got_pa}, {ef, ep});
      2'b10: check("R4 supervisor", got_flt == ef && got_pa == ep, {got_flt, got_pa}, {ef, ep});
      2'b11: check("R5 read/write", got_flt == ef && got_pa == ep, {got_flt, got_pa}, {ef, ep});
      default: check("R6 translate", got_flt == ef && got_pa == ep, {got_flt, got_pa}, {ef, ep});
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [MADDR_W-1:0] cur_base;
    logic [1:0] r9_flt;
    logic [PA_W-1:0] r9_pa;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 reset", req_ready && !rsp_valid && !mem_req,
          {req_ready, rsp_valid, mem_req}, 3'b100);
    lookup(16'h0312, 1'b0, 1'b1, 0);
    expect_result(16'h0000, 16'h0312, 1'b0, 1'b1); // R1 base reset value

    // sweep all pages, both access kinds, both modes
    cur_base = 16'h1000;
    @(negedge clk); base_we = 1'b1; base_wdata = cur_base;
    @(negedge clk); base_we = 1'b0;
    for (int vp = 0; vp < 256; vp++) begin
      for (int m = 0; m < 4; m++) begin
        logic [VA_W-1:0] va;
        va = {8'(vp), 8'(vp * 13 + m * 61)};
        lookup(va, m[0], m[1], (vp % 17 == 0) ? 2 : 0);
        expect_result(cur_base, va, m[0], m[1]);
      end
    end

    // R9 latency independence
    fixed_wait = 0;
    lookup(16'h1A44, 1'b0, 1'b1, 0);
    r9_flt = got_flt; r9_pa = got_pa;
    fixed_wait = 6;
    lookup(16'h1A44, 1'b0, 1'b1, 0);
    check("R9 latency", got_flt == r9_flt && got_pa == r9_pa,
          {got_flt, got_pa}, {r9_flt, r9_pa});
    fixed_wait = -1;

    // R8 write while busy is ignored
    @(negedge clk);
    req_vaddr = 16'h0500; req_write = 1'b0; req_super = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    base_we = 1'b1; base_wdata = 16'h2000;
    @(negedge clk);
    base_we = 1'b0;
    while (!rsp_valid) @(negedge clk);
    rsp_ready = 1'b1; @(negedge clk); rsp_ready = 1'b0;
    lookup(16'h0700, 1'b0, 1'b1, 0);
    check("R8 busy write ignored", seen_addr == cur_base + 16'd28,
          32'(seen_addr), 32'(cur_base + 16'd28));

    // R8 write in the same cycle as acceptance applies afterwards
    @(negedge clk);
    req_vaddr = 16'h0900; req_valid = 1'b1;
    base_we = 1'b1; base_wdata = 16'h3000;
    @(negedge clk);
    req_valid = 1'b0; base_we = 1'b0;
    seen_addr = mem_addr;
    while (!rsp_valid) @(negedge clk);
    rsp_ready = 1'b1; @(negedge clk); rsp_ready = 1'b0;
    check("R8 same-cycle uses old base", seen_addr == cur_base + 16'd36,
          32'(seen_addr), 32'(cur_base + 16'd36));
    lookup(16'h0900, 1'b1, 1'b0, 1);
    expect_result(16'h3000, 16'h0900, 1'b1, 1'b0); // R8 new base applies

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule